// File: doc/BRIEF.md
# Indexed Chipset Configuration Register Port

This block holds a chipset's configuration bytes behind a two-byte I/O window. Software writes a register number to the even byte of the window, then reads or writes the register contents through the odd byte. The window base is a parameter that defaults to 0x22. Storage covers all 256 register numbers. Only a fixed set of register numbers can be read back. Two identification registers return some bits forced low, and every other register number reads as all ones.

Seven registers, numbers 0x09 to 0x0F, describe the memory map. Their contents are driven out in parallel on `map_cfg` for a downstream address decoder. A data write to any of them raises `remap_pulse` in the next cycle, which tells the decoder to recompute the map.

The strobe comes from a two-state machine. `ST_IDLE` is the resting state, and `ST_PULSE` drives the strobe. The transitions are:

- IDLE_TO_PULSE: a data write to a map register.
- PULSE_HOLD: another such write while already in `ST_PULSE`.
- PULSE_TO_IDLE: any cycle without such a write.

Top module: `cfgport_top`

## Requirements
- R1: A write with `io_addr` equal to the even window address loads `io_wdata` into the index register. The index keeps its value until the next index write.
- R2: A write with `io_addr` equal to the odd window address stores `io_wdata` into the register selected by the current index. Any of the 256 index values may be written.
- R3: A read at the even window address returns 0xFF.
- R4: Reading register 0x04 returns its stored value AND 0x1C, so bits 7, 6, 5, 1 and 0 read as zero.
- R5: Reading register 0x08 returns its stored value AND 0x1F, so bits 7, 6 and 5 read as zero.
- R6: Registers 0x05, 0x06, 0x09 through 0x13, and 0x28 through 0x2A read back their full stored value.
- R7: Every other register number reads 0xFF, whatever was written to it.
- R8: `remap_pulse` is high in the cycle after the clock edge at which a data write to register 0x09 to 0x0F commits. It is low in every other cycle.
- R9: A synchronous reset clears the index and all 256 registers to zero and drops `remap_pulse`.
- R10: `map_cfg[8k+7:8k]` carries register 0x09+k, for k from 0 to 6. It changes at the edge that commits the write.
- R11: A write or read at an address outside the window changes no state and returns 0xFF.
- R12: When `io_rd` is low, `io_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one transfer per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| remap_pulse | output | 1 | One cycle per qualifying map write |
| map_cfg | output | 56 | Map registers 0x09..0x0F, lowest number in the low byte |

## Verification
The bench builds the block with its defaults: a 16-bit address, the window at 0x22/0x23, and the map range 0x09 to 0x0F. This puts the window next to its neighbours 0x21 and 0x24/0x25, so a decode that is too wide can be caught. It also makes every readback class reachable: masked, full, and hidden. The map range is kept short enough that writes just inside it (0x0C, 0x0F) and just outside it (0x10) can each be tested for the strobe.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        ST_IDLE,
        ST_PULSE
    } remap_state_t;

    typedef struct packed {
        logic  visible;
        byte_t keep;
    } rb_rule_t;

    // Readback rule per register number: visible flag and the bits kept.
    function automatic rb_rule_t rb_rule(input byte_t ix);
        rb_rule_t r;
        r.visible = 1'b1;
        r.keep    = 8'hFF;
        if (ix == 8'h04)
            r.keep = 8'h1C;
        else if (ix == 8'h08)
            r.keep = 8'h1F;
        else if (ix == 8'h05 || ix == 8'h06)
            r.keep = 8'hFF;
        else if (ix >= 8'h09 && ix <= 8'h13)
            r.keep = 8'hFF;
        else if (ix >= 8'h28 && ix <= 8'h2A)
            r.keep = 8'hFF;
        else
            r.visible = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
    import cfgport_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0022,
    parameter int          MAP_LO    = 9,
    parameter int          MAP_HI    = 15
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  byte_t             idx_q,
    output logic              idx_wr,
    output logic              data_wr,
    output logic              data_rd,
    output logic              map_wr
);
    localparam logic [ADDR_W-1:0] BASE_W  = BASE_ADDR[ADDR_W-1:0];
    localparam byte_t             MAP_LOB = byte_t'(MAP_LO);
    localparam byte_t             MAP_HIB = byte_t'(MAP_HI);

    logic in_window;
    logic in_map;

    always_comb begin
        in_window = (io_addr[ADDR_W-1:1] == BASE_W[ADDR_W-1:1]);
        in_map    = (idx_q >= MAP_LOB) && (idx_q <= MAP_HIB);
        idx_wr    = io_wr && in_window && !io_addr[0];
        data_wr   = io_wr && in_window &&  io_addr[0];
        data_rd   = io_rd && in_window &&  io_addr[0];
        map_wr    = data_wr && in_map;
    end

endmodule

// File: rtl/cfgport_regfile.sv
module cfgport_regfile
    import cfgport_pkg::*;
#(
    parameter int NUM_REGS = 256,
    parameter int MAP_LO   = 9,
    parameter int MAP_HI   = 15,
    localparam int MAP_N   = MAP_HI - MAP_LO + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    idx_wr,
    input  logic                    data_wr,
    input  byte_t                   wdata,
    output byte_t                   idx_q,
    output byte_t                   rd_val,
    output logic [MAP_N*BYTE_W-1:0] map_cfg
);
    byte_t    store [NUM_REGS];
    rb_rule_t rule;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (idx_wr) begin
            idx_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) store[i] <= '0;
        end else if (data_wr) begin
            store[idx_q] <= wdata;
        end
    end

    always_comb begin
        rule   = rb_rule(idx_q);
        rd_val = rule.visible ? (store[idx_q] & rule.keep) : 8'hFF;
    end

    for (genvar k = 0; k < MAP_N; k++) begin : g_map
        assign map_cfg[k*BYTE_W +: BYTE_W] = store[MAP_LO + k];

        assert_map_follow_R10: assert property (@(posedge clk) disable iff (rst)
            (data_wr && idx_q == byte_t'(MAP_LO + k))
            |=> map_cfg[k*BYTE_W +: BYTE_W] == $past(wdata));
    end

    assert_idx_load_R1: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> idx_q == $past(wdata));

    assert_idx_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !idx_wr |=> $stable(idx_q));

    assert_id04_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (idx_q == 8'h04) |-> ((rd_val & 8'hE3) == 8'h00));

    assert_id08_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (idx_q == 8'h08) |-> ((rd_val & 8'hE0) == 8'h00));

endmodule

// File: rtl/cfgport_remap_fsm.sv
module cfgport_remap_fsm
    import cfgport_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic map_wr,
    output logic remap_pulse
);
    remap_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = map_wr ? ST_PULSE : ST_IDLE;
            ST_PULSE: state_d = map_wr ? ST_PULSE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_PULSE: remap_pulse = 1'b1;
            default:  remap_pulse = 1'b0;
        endcase
    end

    assert_remap_follow_R8: assert property (@(posedge clk) disable iff (rst)
        map_wr |=> remap_pulse);

    assert_remap_cause_R8: assert property (@(posedge clk) disable iff (rst)
        !map_wr |=> !remap_pulse);

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0022,
    parameter int          MAP_LO    = 9,
    parameter int          MAP_HI    = 15,
    localparam int         MAP_N     = MAP_HI - MAP_LO + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic                    io_wr,
    input  logic                    io_rd,
    input  logic [7:0]              io_wdata,
    output logic [7:0]              io_rdata,
    output logic                    remap_pulse,
    output logic [MAP_N*BYTE_W-1:0] map_cfg
);
    localparam logic [ADDR_W-1:0] BASE_W = BASE_ADDR[ADDR_W-1:0];

    logic  idx_wr;
    logic  data_wr;
    logic  data_rd;
    logic  map_wr;
    byte_t idx_q;
    byte_t rd_val;

    cfgport_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .MAP_LO    (MAP_LO),
        .MAP_HI    (MAP_HI)
    ) u_decode (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .idx_q   (idx_q),
        .idx_wr  (idx_wr),
        .data_wr (data_wr),
        .data_rd (data_rd),
        .map_wr  (map_wr)
    );

    cfgport_regfile #(
        .NUM_REGS (256),
        .MAP_LO   (MAP_LO),
        .MAP_HI   (MAP_HI)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .idx_wr  (idx_wr),
        .data_wr (data_wr),
        .wdata   (io_wdata),
        .idx_q   (idx_q),
        .rd_val  (rd_val),
        .map_cfg (map_cfg)
    );

    cfgport_remap_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .map_wr      (map_wr),
        .remap_pulse (remap_pulse)
    );

    assign io_rdata = data_rd ? rd_val : 8'hFF;

    assert_rd_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> io_rdata == 8'hFF);

    assert_index_rd_R3: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == BASE_W) |-> io_rdata == 8'hFF);

    assert_window_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr[ADDR_W-1:1] != BASE_W[ADDR_W-1:1])
        |=> ($stable(map_cfg) && !remap_pulse));

endmodule

// File: tb/sim_cfgport_top.sv
`timescale 1ns/1ps
module sim_cfgport_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        remap_pulse;
    logic [55:0] map_cfg;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cfgport_top u0 (
        .clk         (clk),
        .rst         (rst),
        .io_addr     (io_addr),
        .io_wr       (io_wr),
        .io_rd       (io_rd),
        .io_wdata    (io_wdata),
        .io_rdata    (io_rdata),
        .remap_pulse (remap_pulse),
        .map_cfg     (map_cfg)
    );

    typedef struct packed {
        logic        rd;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0022, 8'h04, 8'h00, 4'd1},
        '{1'b0, 16'h0023, 8'hFF, 8'h00, 4'd2},
        '{1'b1, 16'h0023, 8'h00, 8'h1C, 4'd4},  // R4
        '{1'b1, 16'h0022, 8'h00, 8'hFF, 4'd3},  // R3
        '{1'b0, 16'h0022, 8'h08, 8'h00, 4'd1},
        '{1'b0, 16'h0023, 8'hFF, 8'h00, 4'd2},
        '{1'b1, 16'h0023, 8'h00, 8'h1F, 4'd5},  // R5
        '{1'b0, 16'h0022, 8'h05, 8'h00, 4'd1},
        '{1'b0, 16'h0023, 8'hA5, 8'h00, 4'd2},
        '{1'b1, 16'h0023, 8'h00, 8'hA5, 4'd6},  // R6
        '{1'b0, 16'h0022, 8'h06, 8'h00, 4'd1},
        '{1'b0, 16'h0023, 8'h5A, 8'h00, 4'd2},
        '{1'b1, 16'h0023, 8'h00, 8'h5A, 4'd6},
        '{1'b0, 16'h0022, 8'h13, 8'h00, 4'd1},
        '{1'b0, 16'h0023, 8'h3C, 8'h00, 4'd2},
        '{1'b1, 16'h0023, 8'h00, 8'h3C, 4'd6},
        '{1'b0, 16'h0022, 8'h28, 8'h00, 4'd1},
        '{1'b0, 16'h0023, 8'hC3, 8'h00, 4'd2},
        '{1'b1, 16'h0023, 8'h00, 8'hC3, 4'd6},
        '{1'b0, 16'h0022, 8'h2A, 8'h00, 4'd1},
        '{1'b0, 16'h0023, 8'h81, 8'h00, 4'd2},
        '{1'b1, 16'h0023, 8'h00, 8'h81, 4'd6},
        '{1'b0, 16'h0022, 8'h07, 8'h00, 4'd1},
        '{1'b0, 16'h0023, 8'h12, 8'h00, 4'd2},
        '{1'b1, 16'h0023, 8'h00, 8'hFF, 4'd7},  // R7
        '{1'b0, 16'h0022, 8'hFF, 8'h00, 4'd1},
        '{1'b0, 16'h0023, 8'h77, 8'h00, 4'd2},
        '{1'b1, 16'h0023, 8'h00, 8'hFF, 4'd7},
        '{1'b0, 16'h0022, 8'h04, 8'h00, 4'd1},
        '{1'b0, 16'h0023, 8'h55, 8'h00, 4'd2},
        '{1'b1, 16'h0023, 8'h00, 8'h14, 4'd4},
        '{1'b0, 16'h0022, 8'h08, 8'h00, 4'd1},
        '{1'b0, 16'h0023, 8'hE7, 8'h00, 4'd2},
        '{1'b1, 16'h0023, 8'h00, 8'h07, 4'd5},
        '{1'b0, 16'h0022, 8'h05, 8'h00, 4'd1},
        '{1'b1, 16'h0023, 8'h00, 8'hA5, 4'd1},  // R1: index reload
        '{1'b0, 16'h0022, 8'h0A, 8'h00, 4'd1},
        '{1'b0, 16'h0023, 8'h66, 8'h00, 4'd2},
        '{1'b1, 16'h0023, 8'h00, 8'h66, 4'd2}   // R2
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        check("R9 map_cfg", map_cfg, 64'h0);
        check("R9 remap", remap_pulse, 1'b0);
        io_write(16'h0022, 8'h05);
        io_read(16'h0023, rv);
        check("R9 reg05", rv, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                io_read(VECS[i].addr, rv);
                check($sformatf("R%0d vec%0d", VECS[i].req, i), rv, VECS[i].exp);
            end else begin
                io_write(VECS[i].addr, VECS[i].data);
            end
        end

        // R10: map register 0x0A lands in byte 1
        check("R10 map 0x0A", map_cfg[15:8], 8'h66);

        // R8: strobe in the cycle after commit, then low
        io_write(16'h0022, 8'h0C);
        check("R8 index write no strobe", remap_pulse, 1'b0);
        io_write(16'h0023, 8'hAB);
        check("R8 strobe 0x0C", remap_pulse, 1'b1);
        check("R10 map 0x0C", map_cfg[31:24], 8'hAB);
        @(negedge clk);
        check("R8 strobe one cycle", remap_pulse, 1'b0);
        io_write(16'h0022, 8'h0F);
        io_write(16'h0023, 8'h3E);
        check("R8 strobe 0x0F", remap_pulse, 1'b1);
        check("R10 map 0x0F", map_cfg[55:48], 8'h3E);
        io_write(16'h0022, 8'h10);
        io_write(16'h0023, 8'h01);
        check("R8 no strobe 0x10", remap_pulse, 1'b0);
        io_write(16'h0022, 8'h08);
        io_write(16'h0023, 8'h01);
        check("R8 no strobe 0x08", remap_pulse, 1'b0);

        // R11: outside the window
        io_write(16'h0022, 8'h05);
        io_write(16'h0025, 8'h99);
        io_write(16'h0024, 8'h06);
        io_write(16'h0021, 8'h44);
        io_read(16'h0023, rv);
        check("R11 reg05 kept", rv, 8'hA5);
        io_read(16'h0021, rv);
        check("R11 read outside", rv, 8'hFF);
        io_write(16'h0022, 8'h0C);
        io_write(16'h0025, 8'h11);
        check("R11 no strobe", remap_pulse, 1'b0);
        check("R11 map kept", map_cfg[31:24], 8'hAB);

        // R12: no read strobe
        io_write(16'h0022, 8'h05);
        @(negedge clk);
        io_addr = 16'h0023;
        #1 check("R12 idle rdata", io_rdata, 8'hFF);

        // R9: reset clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 map cleared", map_cfg, 64'h0);
        io_write(16'h0022, 8'h05);
        io_read(16'h0023, rv);
        check("R9 reg05 cleared", rv, 8'h00);

        finish_run();
    end

endmodule